// File: doc/BRIEF.md
# Shared-Line Priority Serial Readout Chain

This block models a group of sixteen front-end chips that share a single serial output line during readout of one multiplexer channel. Each chip holds at most one sample for the current channel: a flag saying the sample crossed threshold, and an 8-bit pulse height. Only chips whose flag is set take part. Ownership of the line moves down the chain to the first chip that still holds data. Each owner sends one self-identifying word and then gives up its claim.

Every word is 12 bits long. It carries the chip's 4-bit position in the chain, followed by its pulse height. Bits are sent one per shift-enable pulse. A new-channel strobe loads fresh flags and heights into all chips. It also cancels any word that is partly sent. A chain-empty output reports that no chip holds data, which is the inverse of a wired-OR of all pending flags. A controller uses it to decide when to move to the next channel.

Top module: `pixchain_readout`

## Requirements
- R1: Each word is 12 bits. The upper 4 bits are the sending chip's index in the chain (0 to 15). The lower 8 bits are that chip's captured pulse height.
- R2: When `load` is high at a clock edge, every chip captures its `hit` bit as its pending flag and its byte of `ph_flat` (bits 8k+7..8k for chip k) as its height. The bit position returns to the first bit of a word, and any word in progress is abandoned.
- R3: At most one chip drives the shared line in any cycle.
- R4: The line belongs to the lowest-indexed chip whose pending flag is set. Chips without data are skipped, so words leave in ascending index order.
- R5: A word is sent most significant bit first, tag before height. The line advances one bit at each clock edge where `shift_en` is high and `load` is low. `frame` is high while the first bit of a word is on `sdata`.
- R6: The edge that shifts out a chip's twelfth bit clears that chip's pending flag. In the next cycle, the first bit of the next pending chip's word is on the line.
- R7: `chain_empty` is high exactly when no chip is pending. While it is high, `sdata` and `frame` are 0.
- R8: At an edge where both `shift_en` and `load` are low, `sdata`, `frame` and `chain_empty` do not change.
- R9: After reset no chip is pending: `chain_empty` is 1, and `sdata` and `frame` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | New-channel strobe: capture flags and heights |
| hit | input | 16 | Per-chip above-threshold flags, bit k for chip k |
| ph_flat | input | 128 | Per-chip pulse heights, byte k for chip k |
| shift_en | input | 1 | Advance the serial line by one bit |
| sdata | output | 1 | Shared serial data line |
| frame | output | 1 | High while a word's first bit is presented |
| chain_empty | output | 1 | No chip holds unread data |

## Verification
The assertions check several properties on every cycle. The grant is one-hot or zero, and it goes to the lowest pending chip. A finished word removes exactly one pending flag. A load copies `hit` into the pending set. The line is quiet when the chain is empty, and state holds when neither shift nor load is active. Whether the serial bit pattern really spells tag then height, in ascending chip order, can be shown only by the bench. The bench reassembles whole words from `sdata`, and it also covers abort by a mid-word load and long stalls inside a word.

// File: rtl/pixchain_pkg.sv
package pixchain_pkg;
  localparam int DEF_CHIPS = 16;
  localparam int DEF_PH_W  = 8;

  // position in a word of the bit sent at step idx (MSB first)
  function automatic int unsigned send_pos(input int unsigned idx, input int unsigned width);
    return width - 1 - idx;
  endfunction

  // assemble tag and height into one word value
  function automatic logic [31:0] pack_word(input int unsigned tag, input logic [31:0] height,
                                            input int unsigned ph_w);
    return (32'(tag) << ph_w) | height;
  endfunction
endpackage

// File: rtl/pixchain_cell.sv
module pixchain_cell
  import pixchain_pkg::*;
#(
  parameter int PH_W    = 8,
  parameter int TAG_W   = 4,
  parameter int WORD_W  = TAG_W + PH_W,
  parameter int IDX_W   = $clog2(WORD_W),
  parameter int CHIP_ID = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             hit_i,
  input  logic [PH_W-1:0]  ph_i,
  input  logic             word_done_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             token_i,
  output logic             pending_o,
  output logic             grant_o,
  output logic             token_o,
  output logic             drive_o
);
  logic [PH_W-1:0]   ph_q;
  logic [WORD_W-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_o <= 1'b0;
      ph_q      <= '0;
    end else if (load_i) begin
      pending_o <= hit_i;
      ph_q      <= ph_i;
    end else if (word_done_i && grant_o) begin
      pending_o <= 1'b0;
    end
  end

  // daisy chain: token passes on only when this chip has nothing to send
  assign grant_o = token_i & pending_o;
  assign token_o = token_i & ~pending_o;

  assign word = WORD_W'(pack_word(CHIP_ID, 32'(ph_q), PH_W));

  always_comb begin
    drive_o = 1'b0;
    for (int b = 0; b < WORD_W; b++) begin
      if (send_pos(int'(bit_idx_i), WORD_W) == b) drive_o = grant_o & word[b];
    end
  end
endmodule

// File: rtl/pixchain_seq.sv
module pixchain_seq #(
  parameter int WORD_W = 12,
  parameter int IDX_W  = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             shift_en_i,
  input  logic             busy_i,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             word_done_o,
  output logic             frame_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_W - 1);

  logic step;
  assign step        = shift_en_i & busy_i & ~load_i;
  assign word_done_o = step & (bit_idx_o == LAST);
  assign frame_o     = busy_i & (bit_idx_o == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           bit_idx_o <= '0;
    else if (load_i)      bit_idx_o <= '0;
    else if (word_done_o) bit_idx_o <= '0;
    else if (step)        bit_idx_o <= bit_idx_o + 1'b1;
  end
endmodule

// File: rtl/pixchain_readout.sv
module pixchain_readout
  import pixchain_pkg::*;
#(
  parameter int N_CHIPS = DEF_CHIPS,
  parameter int PH_W    = DEF_PH_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [N_CHIPS-1:0]      hit,
  input  logic [N_CHIPS*PH_W-1:0] ph_flat,
  input  logic                    shift_en,
  output logic                    sdata,
  output logic                    frame,
  output logic                    chain_empty
);
  localparam int TAG_W  = $clog2(N_CHIPS);
  localparam int WORD_W = TAG_W + PH_W;
  localparam int IDX_W  = $clog2(WORD_W);

  // named internal events, observed by the checker
  logic [N_CHIPS-1:0] pending;
  logic [N_CHIPS-1:0] grant;
  logic [N_CHIPS-1:0] drive;
  logic [N_CHIPS:0]   token;
  logic [IDX_W-1:0]   bit_idx;
  logic               word_done;
  logic               busy;

  assign token[0] = 1'b1;

  for (genvar k = 0; k < N_CHIPS; k++) begin : g_cell
    pixchain_cell #(
      .PH_W(PH_W), .TAG_W(TAG_W), .WORD_W(WORD_W), .IDX_W(IDX_W), .CHIP_ID(k)
    ) u_cell (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load),
      .hit_i       (hit[k]),
      .ph_i        (ph_flat[k*PH_W +: PH_W]),
      .word_done_i (word_done),
      .bit_idx_i   (bit_idx),
      .token_i     (token[k]),
      .pending_o   (pending[k]),
      .grant_o     (grant[k]),
      .token_o     (token[k+1]),
      .drive_o     (drive[k])
    );
  end

  assign busy = |pending;

  pixchain_seq #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .shift_en_i  (shift_en),
    .busy_i      (busy),
    .bit_idx_o   (bit_idx),
    .word_done_o (word_done),
    .frame_o     (frame)
  );

  assign sdata       = |drive;
  assign chain_empty = ~busy;
endmodule

// File: rtl/pixchain_readout_chk.sv
module pixchain_readout_chk #(
  parameter int N_CHIPS = 16,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               load,
  input logic               shift_en,
  input logic [N_CHIPS-1:0] hit,
  input logic               sdata,
  input logic               frame,
  input logic               chain_empty,
  input logic [N_CHIPS-1:0] pending,
  input logic [N_CHIPS-1:0] grant,
  input logic [IDX_W-1:0]   bit_idx,
  input logic               word_done
);
  p_one_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_lowest_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> ((pending & (grant - 1'b1)) == '0) && ((grant & pending) == grant));

  p_granted_when_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pending != '0) |-> (grant != '0));

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (pending == $past(hit)) && (bit_idx == '0));

  p_frame_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame |-> (bit_idx == '0) && !chain_empty);

  p_clear_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> $countones(pending) == $countones($past(pending)) - 1);

  p_handoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && $countones(pending) > 1) |=> frame);

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chain_empty |-> !sdata && !frame && (pending == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !load) |=> $stable(pending) && $stable(bit_idx) && $stable(sdata));
endmodule

bind pixchain_readout pixchain_readout_chk #(.N_CHIPS(N_CHIPS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .shift_en(shift_en), .hit(hit),
  .sdata(sdata), .frame(frame), .chain_empty(chain_empty), .pending(pending),
  .grant(grant), .bit_idx(bit_idx), .word_done(word_done)
);

// File: tb/pixchain_readout_bench.sv
`timescale 1ns/1ps
module pixchain_readout_bench;
  localparam int N  = 16;
  localparam int PW = 8;
  localparam int WW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic [N-1:0]  hit = '0;
  logic [N*PW-1:0] ph_flat = '0;
  logic          shift_en = 1'b0;
  logic          sdata, frame, chain_empty;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [N-1:0]  m_pend = '0;
  logic [PW-1:0] m_ph [N];
  int            m_bit = 0;

  always #2.5 clk = ~clk;

  pixchain_readout u_pixchain_readout (
    .clk(clk), .rst_n(rst_n), .load(load), .hit(hit), .ph_flat(ph_flat),
    .shift_en(shift_en), .sdata(sdata), .frame(frame), .chain_empty(chain_empty)
  );

  function automatic int first_set(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  // expected word: chip index in the top 4 bits, height below
  function automatic logic [WW-1:0] exp_word(input int idx, input logic [PW-1:0] h);
    return WW'(idx * 256 + int'(h));
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    int g;
    logic [WW-1:0] w;
    logic e_sd;
    g = first_set(m_pend);
    e_sd = 1'b0;
    if (g >= 0) begin
      w = exp_word(g, m_ph[g]);
      e_sd = w[WW-1-m_bit];
    end
    check(chain_empty == (g < 0), "R7", "chain_empty", chain_empty, g < 0);
    check(sdata == e_sd, "R5", "sdata", sdata, e_sd);
    check(frame == (g >= 0 && m_bit == 0), "R5", "frame", frame, g >= 0 && m_bit == 0);
  endtask

  // called at a negedge: compare, drive, cross the posedge, update model
  task automatic step(input bit ld, input logic [N-1:0] h, input logic [N*PW-1:0] p, input bit sh);
    int g;
    compare();
    load = ld; hit = h; ph_flat = p; shift_en = sh;
    @(posedge clk);
    if (ld) begin
      m_pend = h;
      for (int i = 0; i < N; i++) m_ph[i] = p[i*PW +: PW];
      m_bit = 0;
    end else if (sh && m_pend != '0) begin
      if (m_bit == WW - 1) begin
        g = first_set(m_pend);
        m_pend[g] = 1'b0;
        m_bit = 0;
      end else m_bit++;
    end
    @(negedge clk);
  endtask

  function automatic logic [N*PW-1:0] rand_ph();
    logic [N*PW-1:0] p;
    for (int i = 0; i < N; i++) p[i*PW +: PW] = PW'($urandom_range(0, 255));
    return p;
  endfunction

  // load a set, then shift continuously and rebuild words from sdata
  task automatic load_and_drain(input logic [N-1:0] h, input logic [N*PW-1:0] p);
    int cnt;
    int k;
    logic [WW-1:0] rx;
    step(1'b1, h, p, 1'b0);
    cnt = $countones(h);
    k = 0;
    for (int i = 0; i < N; i++) begin
      if (h[i]) begin
        rx = '0;
        for (int b = 0; b < WW; b++) begin
          check(!chain_empty, "R6", "empty during word", chain_empty, 0);
          rx = {rx[WW-2:0], sdata};
          step(1'b0, h, p, 1'b1);
        end
        // R1 word layout, R3 single driver, R4 ascending order
        check(rx == exp_word(i, p[i*PW +: PW]), "R4", "word", rx, exp_word(i, p[i*PW +: PW]));
        check(rx[WW-1:PW] == 4'(i), "R1", "tag", rx[WW-1:PW], i);
        k++;
      end
    end
    check(k == cnt && chain_empty, "R6", "empty after last word", chain_empty, 1);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N*PW-1:0] p;
    logic hold_sd, hold_fr;
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) m_ph[i] = '0;
    repeat (3) @(negedge clk);
    check(chain_empty == 1'b1, "R9", "empty at reset", chain_empty, 1);
    check(sdata == 1'b0 && frame == 1'b0, "R9", "quiet at reset", {sdata, frame}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // every chip has data
    load_and_drain({N{1'b1}}, rand_ph());
    // sparse set, skipping empty chips
    load_and_drain(16'h8208, rand_ph());
    load_and_drain(16'h0001, rand_ph());
    load_and_drain(16'h8000, rand_ph());
    // no chip has data
    step(1'b1, '0, rand_ph(), 1'b1);
    check(chain_empty, "R7", "empty load", chain_empty, 1);

    // R2: abort mid-word with a new load
    p = rand_ph();
    step(1'b1, 16'h0030, p, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, 16'h0030, p, 1'b1);
    load_and_drain(16'h0402, rand_ph());

    // R8: stall inside a word
    p = rand_ph();
    step(1'b1, 16'h0100, p, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 16'h0100, p, 1'b1);
    hold_sd = sdata; hold_fr = frame;
    for (int i = 0; i < 10; i++) begin
      step(1'b0, $urandom, rand_ph(), 1'b0);
      check(sdata == hold_sd && frame == hold_fr && !chain_empty, "R8", "stall", sdata, hold_sd);
    end

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      logic ld;
      ld = ($urandom_range(0, 39) == 0);
      step(ld, N'($urandom) & N'($urandom), rand_ph(), $urandom_range(0, 3) != 0);
    end
    compare();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule